// File: doc/BRIEF.md
# TDM Audio Frame Transmitter

This block is the master end of a multi-channel time-division-multiplexed audio serial link. From a fast system clock it makes a serial bit clock through a clock-enable divider. Each frame it takes one two's-complement PCM word for every channel from a parallel input and sends the words one after another on a single data line. A frame-sync output marks where each frame starts. The bit clock rate equals the sample rate times the channel count times the block width; for example, eight 32-bit blocks at 48 kHz need 12.288 MHz.

Each channel occupies a fixed-width block. The audio word goes out first, most significant bit leading, and zeros fill the rest of the block. Two static pins set the link format. One pin picks the frame-sync width: one bit period, or one whole channel block. The other pin picks the data alignment: the first data bit starts with the frame-sync rising edge, or it starts one bit period later. Data and frame sync change on the falling edge of the bit clock, so a receiver samples them on the rising edge.

The samples for a frame are captured into a holding register when that frame starts. A one-cycle ready pulse then asks the supplier for the next frame's words. A frame that is being sent can therefore never mix words from two different frames.

Top module: `tdm_frame_tx`

## Requirements
- R1: A frame is NUM_CH blocks of BLOCK_W bit periods each, sent back to back. Channel 0 goes first. Channel c is taken from samples_i[c*WORD_W +: WORD_W].
- R2: Within a block, the WORD_W bits of the word go out most significant bit first. The remaining BLOCK_W-WORD_W bit periods carry 0.
- R3: With cfg_fs_wide=0, fsync_o is high for exactly the first bit period of each frame.
- R4: With cfg_fs_wide=1, fsync_o is high for the first BLOCK_W bit periods of each frame, which is all of the channel 0 block period.
- R5: With cfg_delay=0, the first data bit of channel 0 is in the same bit period as the fsync_o rise. With cfg_delay=1, the whole data stream is one bit period later. The last bit of a frame then goes out in the first bit period of the next frame.
- R6: sclk_o has a period of 2*HALF_DIV system clock cycles. It stays HALF_DIV cycles high and HALF_DIV cycles low.
- R7: sdata_o and fsync_o change only on the system clock edge where sclk_o falls. They are stable while sclk_o is high.
- R8: samples_i is captured once per frame, at the frame's first bit period. Changes to samples_i later in the frame have no effect on the data of that frame.
- R9: ready_o is a single system-cycle pulse once per frame, every 2*HALF_DIV*NUM_CH*BLOCK_W cycles. It is high in the cycle where sclk_o falls into the first bit period, together with the fsync_o rise.
- R10: During reset, sclk_o, fsync_o, sdata_o and ready_o are low. When sclk_o rises for the first time after reset, fsync_o and sdata_o are still low. The first frame starts at the first sclk_o fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fs_wide | input | 1 | Frame-sync width: 0 = one bit period, 1 = one channel block |
| cfg_delay | input | 1 | Data alignment: 0 = with the frame-sync rise, 1 = one bit period later |
| samples_i | input | NUM_CH*WORD_W | Words for the next frame; channel c in bits [c*WORD_W +: WORD_W] |
| ready_o | output | 1 | One-cycle pulse at frame start asking for the next frame's words |
| sclk_o | output | 1 | Serial bit clock |
| fsync_o | output | 1 | Frame-sync pulse |
| sdata_o | output | 1 | Serial data |

## Verification
Bit period n of the stream, counted from the first frame, is driven at the (n+1)-th sclk_o fall and is due at the (n+2)-th sclk_o rise, where a receiver samples it. The bench therefore samples the outputs at every sclk_o rise and computes the expected fsync and data bits arithmetically from n, the alignment, the frame-sync width and the words that belong to each frame. ready_o is due in the same system cycle as the sclk_o fall that starts a frame. The bench checks that cycle and the frame spacing. It disturbs samples_i in the middle of a frame and checks that the frame in flight is not affected. A second instance whose word fills the whole block shows that a real data bit is carried into the next frame in delayed alignment.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    typedef enum logic {
        FS_SINGLE_BIT = 1'b0,
        FS_FULL_BLOCK = 1'b1
    } fs_width_e;

    typedef enum logic {
        ALIGN_ON_EDGE  = 1'b0,
        ALIGN_ONE_LATE = 1'b1
    } data_align_e;

    // width of a counter that must index n distinct values
    function automatic int ptr_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tdm_bclk_gen.sv
module tdm_bclk_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic sclk_o,
    output logic fall_tick_o
);
    localparam int CW = tdm_tx_pkg::ptr_w(HALF_DIV);
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sclk;
    } div_t;

    div_t div_d, div_q;
    logic at_edge;

    assign at_edge = (div_q.cnt == CNT_LAST);

    always_comb begin
        div_d = div_q;
        if (at_edge) begin
            div_d.cnt  = '0;
            div_d.sclk = ~div_q.sclk;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign sclk_o      = div_q.sclk;
    // true in the cycle whose closing edge takes sclk from high to low
    assign fall_tick_o = at_edge & div_q.sclk;

endmodule

// File: rtl/tdm_slot_seq.sv
module tdm_slot_seq #(
    parameter int NUM_CH  = 8,
    parameter int BLOCK_W = 32
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      adv_i,
    output logic [tdm_tx_pkg::ptr_w(NUM_CH)-1:0]      cur_ch_o,
    output logic [tdm_tx_pkg::ptr_w(BLOCK_W)-1:0]     cur_bit_o,
    output logic [tdm_tx_pkg::ptr_w(NUM_CH)-1:0]      nxt_ch_o,
    output logic [tdm_tx_pkg::ptr_w(BLOCK_W)-1:0]     nxt_bit_o,
    output logic                                      nxt_first_o
);
    localparam int CHW = tdm_tx_pkg::ptr_w(NUM_CH);
    localparam int BTW = tdm_tx_pkg::ptr_w(BLOCK_W);
    localparam logic [CHW-1:0] CH_LAST = CHW'(NUM_CH - 1);
    localparam logic [BTW-1:0] BT_LAST = BTW'(BLOCK_W - 1);

    typedef struct packed {
        logic [CHW-1:0] ch;
        logic [BTW-1:0] bt;
    } ptr_t;

    ptr_t ptr_d, ptr_q, step;

    // position that follows the current one, wrapping at the frame end
    always_comb begin
        step = ptr_q;
        if (ptr_q.bt == BT_LAST) begin
            step.bt = '0;
            step.ch = (ptr_q.ch == CH_LAST) ? '0 : ptr_q.ch + 1'b1;
        end else begin
            step.bt = ptr_q.bt + 1'b1;
        end
    end

    always_comb begin
        ptr_d = ptr_q;
        if (adv_i) begin
            ptr_d = step;
        end
    end

    // reset to the last position so the first advance opens a frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q.ch <= CH_LAST;
            ptr_q.bt <= BT_LAST;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign cur_ch_o    = ptr_q.ch;
    assign cur_bit_o   = ptr_q.bt;
    assign nxt_ch_o    = step.ch;
    assign nxt_bit_o   = step.bt;
    assign nxt_first_o = (step.ch == '0) && (step.bt == '0);

endmodule

// File: rtl/tdm_word_sel.sv
module tdm_word_sel #(
    parameter int NUM_CH  = 8,
    parameter int BLOCK_W = 32,
    parameter int WORD_W  = 24
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      adv_i,
    input  logic                                      load_i,
    input  logic                                      use_live_i,
    input  logic [NUM_CH*WORD_W-1:0]                  samples_i,
    input  logic [tdm_tx_pkg::ptr_w(NUM_CH)-1:0]      sel_ch_i,
    input  logic [tdm_tx_pkg::ptr_w(BLOCK_W)-1:0]     sel_bit_i,
    output logic                                      sdata_o
);
    localparam int BTW = tdm_tx_pkg::ptr_w(BLOCK_W);
    localparam int PAD = BLOCK_W - WORD_W;

    typedef logic [NUM_CH-1:0][WORD_W-1:0] bank_t;

    typedef struct packed {
        bank_t hold;
        logic  sdata;
    } sel_t;

    sel_t st_d, st_q;
    bank_t live, src;
    logic [WORD_W-1:0]  word;
    logic [BLOCK_W-1:0] blk;
    logic [BTW-1:0]     pos;

    assign live = samples_i;
    // on the opening tick in edge alignment the word is taken straight from the input
    assign src  = (load_i && use_live_i) ? live : st_q.hold;
    assign word = src[sel_ch_i];

    generate
        if (PAD > 0) begin : g_pad
            assign blk = {word, {PAD{1'b0}}};
        end else begin : g_nopad
            assign blk = word;
        end
    endgenerate

    assign pos = BTW'(BLOCK_W - 1) - sel_bit_i;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.hold = live;
        end
        if (adv_i) begin
            st_d.sdata = blk[pos];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdata_o = st_q.sdata;

endmodule

// File: rtl/tdm_frame_tx.sv
module tdm_frame_tx #(
    parameter int NUM_CH   = 8,
    parameter int BLOCK_W  = 32,
    parameter int WORD_W   = 24,
    parameter int HALF_DIV = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_fs_wide,
    input  logic                     cfg_delay,
    input  logic [NUM_CH*WORD_W-1:0] samples_i,
    output logic                     ready_o,
    output logic                     sclk_o,
    output logic                     fsync_o,
    output logic                     sdata_o
);
    import tdm_tx_pkg::*;

    localparam int CHW = ptr_w(NUM_CH);
    localparam int BTW = ptr_w(BLOCK_W);

    typedef struct packed {
        logic fsync;
        logic ready;
    } ctl_t;

    fs_width_e   fs_mode;
    data_align_e align;
    logic        adv, load;
    logic [CHW-1:0] cur_ch, nxt_ch, sel_ch;
    logic [BTW-1:0] cur_bit, nxt_bit, sel_bit;
    logic        nxt_first;
    ctl_t        ctl_d, ctl_q;

    assign fs_mode = fs_width_e'(cfg_fs_wide);
    assign align   = data_align_e'(cfg_delay);

    tdm_bclk_gen #(
        .HALF_DIV (HALF_DIV)
    ) i_bclk (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_o      (sclk_o),
        .fall_tick_o (adv)
    );

    tdm_slot_seq #(
        .NUM_CH  (NUM_CH),
        .BLOCK_W (BLOCK_W)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv_i       (adv),
        .cur_ch_o    (cur_ch),
        .cur_bit_o   (cur_bit),
        .nxt_ch_o    (nxt_ch),
        .nxt_bit_o   (nxt_bit),
        .nxt_first_o (nxt_first)
    );

    assign load = adv & nxt_first;

    // late alignment sends the position one period behind the frame position
    assign sel_ch  = (align == ALIGN_ONE_LATE) ? cur_ch  : nxt_ch;
    assign sel_bit = (align == ALIGN_ONE_LATE) ? cur_bit : nxt_bit;

    tdm_word_sel #(
        .NUM_CH  (NUM_CH),
        .BLOCK_W (BLOCK_W),
        .WORD_W  (WORD_W)
    ) i_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (adv),
        .load_i     (load),
        .use_live_i (align == ALIGN_ON_EDGE),
        .samples_i  (samples_i),
        .sel_ch_i   (sel_ch),
        .sel_bit_i  (sel_bit),
        .sdata_o    (sdata_o)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.ready = 1'b0;
        if (adv) begin
            ctl_d.ready = nxt_first;
            ctl_d.fsync = (fs_mode == FS_FULL_BLOCK) ? (nxt_ch == '0) : nxt_first;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ready_o = ctl_q.ready;
    assign fsync_o = ctl_q.fsync;

endmodule

// File: rtl/tdm_frame_tx_chk.sv
module tdm_frame_tx_chk #(
    parameter int HALF_DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic cfg_fs_wide,
    input logic ready_o,
    input logic sclk_o,
    input logic fsync_o,
    input logic sdata_o
);
    logic        sclk_prev_q;
    logic        toggled_q;
    logic [15:0] run_q;

    // cycles since the last sclk change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
            toggled_q   <= 1'b0;
            run_q       <= '0;
        end else begin
            sclk_prev_q <= sclk_o;
            if (sclk_o != sclk_prev_q) begin
                run_q     <= '0;
                toggled_q <= 1'b1;
            end else begin
                run_q <= run_q + 16'd1;
            end
        end
    end

    p_sclk_half_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (toggled_q && (sclk_o != sclk_prev_q)) |-> (run_q == 16'(HALF_DIV - 1)));

    p_stable_while_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> ($stable(sdata_o) && $stable(fsync_o)));

    p_ready_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !ready_o);

    p_ready_at_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (!sclk_o && $past(sclk_o)));

    p_fsync_rise_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsync_o) |-> ready_o);

    p_narrow_fsync_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_fs_wide && $past(fsync_o) && !sclk_o && $past(sclk_o)) |-> !fsync_o);

endmodule

bind tdm_frame_tx tdm_frame_tx_chk #(
    .HALF_DIV (HALF_DIV)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_fs_wide (cfg_fs_wide),
    .ready_o     (ready_o),
    .sclk_o      (sclk_o),
    .fsync_o     (fsync_o),
    .sdata_o     (sdata_o)
);

// File: tb/test_tdm_frame_tx.sv
`timescale 1ns/1ps
module test_tdm_frame_tx;
    localparam int NCH    = 4;
    localparam int BW     = 8;
    localparam int WWA    = 6;
    localparam int WWB    = 8;
    localparam int HD     = 2;
    localparam int FRAME  = NCH * BW;
    localparam int FR_SYS = FRAME * 2 * HD;
    localparam int NFR    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_fs_wide = 1'b0;
    logic cfg_delay = 1'b0;
    logic [NCH*WWA-1:0] samp_a;
    logic [NCH*WWB-1:0] samp_b;
    logic ready, sclk, fsync, sdata;
    logic ready_b, sclk_b, fsync_b, sdata_b;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    tdm_frame_tx #(.NUM_CH(NCH), .BLOCK_W(BW), .WORD_W(WWA), .HALF_DIV(HD)) i_tdm_frame_tx (
        .clk(clk), .rst_n(rst_n), .cfg_fs_wide(cfg_fs_wide), .cfg_delay(cfg_delay),
        .samples_i(samp_a), .ready_o(ready), .sclk_o(sclk), .fsync_o(fsync), .sdata_o(sdata));

    tdm_frame_tx #(.NUM_CH(NCH), .BLOCK_W(BW), .WORD_W(WWB), .HALF_DIV(HD)) i_tdm_frame_tx_full (
        .clk(clk), .rst_n(rst_n), .cfg_fs_wide(cfg_fs_wide), .cfg_delay(cfg_delay),
        .samples_i(samp_b), .ready_o(ready_b), .sclk_o(sclk_b), .fsync_o(fsync_b), .sdata_o(sdata_b));

    function automatic logic [31:0] pat(input int f, input int ch, input int ww);
        logic [31:0] v;
        case (f % 4)
            1:       v = 32'hFFFF_FFFF;
            2:       v = 32'd1 << (ww - 1);
            default: v = 32'(f * 23 + ch * 13 + 7) ^ 32'(ch << 2);
        endcase
        return v & ((32'd1 << ww) - 32'd1);
    endfunction

    function automatic logic [NCH*WWA-1:0] vec_a(input int f);
        logic [NCH*WWA-1:0] v;
        for (int c = 0; c < NCH; c++) v[c*WWA +: WWA] = WWA'(pat(f, c, WWA));
        return v;
    endfunction

    function automatic logic [NCH*WWB-1:0] vec_b(input int f);
        logic [NCH*WWB-1:0] v;
        for (int c = 0; c < NCH; c++) v[c*WWB +: WWB] = WWB'(pat(f, c, WWB));
        return v;
    endfunction

    // expected data bit in stream period n
    function automatic logic exp_bit(input int n, input logic dly, input int ww);
        int d, f, s, ch, b;
        logic [31:0] w;
        d = dly ? n - 1 : n;
        if (d < 0) return 1'b0;
        f  = d / FRAME;
        s  = d % FRAME;
        ch = s / BW;
        b  = s % BW;
        if (b >= ww) return 1'b0;
        w = pat(f, ch, ww);
        return w[ww - 1 - b];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_cfg(input logic wide, input logic dly);
        int rises, ready_cnt, run, cyc, last_rdy, n, s;
        logic prev_sclk, prev_fs, prev_sd, exp_fs;
        bit seen;
        rst_n = 1'b0;
        cfg_fs_wide = wide;
        cfg_delay = dly;
        samp_a = vec_a(0);
        samp_b = vec_b(0);
        repeat (3) @(negedge clk);
        chk(sclk == 1'b0,  "R10 reset sclk",  int'(sclk),  0);
        chk(fsync == 1'b0, "R10 reset fsync", int'(fsync), 0);
        chk(sdata == 1'b0, "R10 reset sdata", int'(sdata), 0);
        chk(ready == 1'b0, "R10 reset ready", int'(ready), 0);
        rst_n = 1'b1;
        rises = 0; ready_cnt = 0; run = 0; cyc = 0; last_rdy = 0; seen = 1'b0;
        prev_sclk = 1'b0; prev_fs = 1'b0; prev_sd = 1'b0;
        while (rises < NFR * FRAME + 1) begin
            @(negedge clk);
            cyc++;
            if (sclk != prev_sclk) begin
                if (seen) chk(run == HD, "R6 sclk half period", run, HD);
                seen = 1'b1;
                run = 1;
            end else begin
                run++;
            end
            if (sclk && prev_sclk) begin
                chk((fsync == prev_fs) && (sdata == prev_sd), "R7 stable while sclk high",
                    int'({fsync, sdata}), int'({prev_fs, prev_sd}));
            end
            if (sclk && !prev_sclk) begin
                if (rises == 0) begin
                    chk(!fsync && !sdata, "R10 idle at first rise", int'({fsync, sdata}), 0);
                end else begin
                    n = rises - 1;
                    s = n % FRAME;
                    exp_fs = wide ? (s < BW) : (s == 0);
                    if (wide) chk(fsync == exp_fs, "R4 block-wide fsync", int'(fsync), int'(exp_fs));
                    else      chk(fsync == exp_fs, "R3 one-bit fsync",    int'(fsync), int'(exp_fs));
                    if (dly) begin
                        chk(sdata == exp_bit(n, dly, WWA), "R5 late data padded",
                            int'(sdata), int'(exp_bit(n, dly, WWA)));
                        chk(sdata_b == exp_bit(n, dly, WWB), "R5 late data wrap full word",
                            int'(sdata_b), int'(exp_bit(n, dly, WWB)));
                    end else begin
                        chk(sdata == exp_bit(n, dly, WWA), "R1 R2 data padded",
                            int'(sdata), int'(exp_bit(n, dly, WWA)));
                        chk(sdata_b == exp_bit(n, dly, WWB), "R1 R2 data full word",
                            int'(sdata_b), int'(exp_bit(n, dly, WWB)));
                    end
                    // R8: disturb the input mid-frame, then restore before the next capture
                    if (s == FRAME / 2) begin
                        samp_a = ~vec_a(ready_cnt);
                        samp_b = ~vec_b(ready_cnt);
                    end
                    if (s == (3 * FRAME) / 4) begin
                        samp_a = vec_a(ready_cnt);
                        samp_b = vec_b(ready_cnt);
                    end
                end
                rises++;
            end
            if (ready) begin
                chk(!sclk && prev_sclk, "R9 ready at sclk fall", int'({prev_sclk, sclk}), 2);
                if (ready_cnt > 0) chk(cyc - last_rdy == FR_SYS, "R9 ready spacing", cyc - last_rdy, FR_SYS);
                last_rdy = cyc;
                ready_cnt++;
                samp_a = vec_a(ready_cnt);
                samp_b = vec_b(ready_cnt);
            end
            prev_sclk = sclk;
            prev_fs = fsync;
            prev_sd = sdata;
        end
        chk(ready_cnt >= NFR, "R9 ready count", ready_cnt, NFR);
    endtask

    initial begin
        samp_a = '0;
        samp_b = '0;
        run_cfg(1'b0, 1'b0);
        run_cfg(1'b1, 1'b0);
        run_cfg(1'b0, 1'b1);
        run_cfg(1'b1, 1'b1);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule